// File: doc/BRIEF.md
# Dual-Class Prioritized Interrupt Controller

This block collects 64 level-driven interrupt sources and presents them to a processor through two request lines: a normal request and a fast request. Every source carries an enable bit, a class bit that routes it to the fast line when set, and a 4-bit priority. A 5-bit threshold filters the normal line. Software drives the block through a simple 32-bit register port with a byte address, a write strobe, a read strobe and combinational read data.

A source becomes pending on a rising edge of its input and stops being pending on a falling edge. Software can also overwrite either half of the pending vector directly. Reading one of the two vector registers identifies a source and acknowledges it by clearing its pending bit. The normal vector picks the pending normal source with the highest priority. The fast vector picks the lowest-numbered pending fast source. Both request lines are decoded from registered state.

Top module: `dual_irq_ctrl`

## Requirements
- R1: After reset, all pending, enable, class, priority and control state is zero. The threshold reads 0x1F. Both request outputs are low.
- R2: Writing word 2 sets the enable bit numbered by write data bits [5:0]. Writing word 3 clears that bit. Words 2 and 3 read as zero.
- R3: Words 4/5 hold enable bits 63:32 and 31:0. Words 6/7 hold class bits 63:32 and 31:0, where 1 means fast. All four can be written and read back.
- R4: Priority words are at word indices 8 to 15. Word index 15 covers sources 0–7 and word index 8 covers sources 56–63. Source n uses bits 4*(n mod 8)+3 down to 4*(n mod 8). The words read back as written.
- R5: fast_irq is high exactly when some source is pending, enabled and fast.
- R6: The threshold is at word 1 and is 5 bits wide. When it is 0x1F, norm_irq is high if any enabled normal source is pending. Otherwise norm_irq is high only if such a source has a priority strictly greater than the threshold.
- R7: Reading word 16 returns (source << 16) | priority for the pending, enabled, normal source with the highest priority. Ties go to the higher source number. The read clears that source's pending bit. With no candidate the read returns 0xFFFFFFFF.
- R8: Reading word 17 returns the number of the lowest-numbered pending, enabled, fast source and clears its pending bit. With no candidate the read returns 0xFFFFFFFF.
- R9: An input is sampled at each clock. A rising edge sets its pending bit one clock later and a falling edge clears it. When an acknowledge read and a rising edge of the same source fall in the same cycle, the clear wins.
- R10: Writing word 20 or 21 overwrites pending bits 63:32 or 31:0. Those words read as zero. Words 18/19 return the raw pending halves. Words 22/23 return pending&enable&~class. Words 24/25 return pending&enable&class.
- R11: Writes to words 16–19 and 22–25 change nothing. Writes to byte offsets 0x100–0x2FC change nothing. Reads of unmapped words return zero.
- R12: The control word (word 0) keeps only bits 24, 22, 21, 20, 19 and 18 of a write (mask 0x017C0000).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 64 | Source levels |
| bus_addr | input | 12 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (triggers acknowledge side effects) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| norm_irq | output | 1 | Normal request |
| fast_irq | output | 1 | Fast request |

## Verification
Read data is valid in the same cycle as the address. The bench therefore samples it one time unit after the falling edge on which it drives the read, before the rising edge that commits any acknowledge. Register writes, force writes and acknowledge clears take effect at the next rising edge. Input edges are also captured at the next rising edge, so a new input level shows in the pending registers and on the request lines one clock after it is applied. Every check reads or looks at the lines on the falling edge that follows that rising edge, never at the edge itself.

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl #(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [63:0]   src_in,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          norm_irq,
  output logic          fast_irq
);
  localparam int NS = 64;
  localparam int IW = AW - 2;
  localparam logic [31:0] CTRL_MASK = 32'h017C_0000;

  logic [NS-1:0] pend, en, typ, src_q, pnext;
  logic [31:0]   prio_w [8];
  logic [31:0]   ctrl;
  logic [4:0]    thr;

  wire [IW-1:0] idx = bus_addr[AW-1:2];
  wire [NS-1:0] npend = pend & en & ~typ;
  wire [NS-1:0] fpend = pend & en & typ;

  logic       nv_hit, nv_over, fv_hit;
  logic [5:0] nv_num, fv_num;
  logic [3:0] nv_pri, p;

  always_comb begin
    nv_hit = 1'b0; nv_over = 1'b0; nv_num = '0; nv_pri = '0; p = '0;
    for (int i = 0; i < NS; i++) begin
      p = prio_w[i/8][4*(i%8) +: 4];
      if (npend[i]) begin
        if (!nv_hit || p >= nv_pri) begin
          nv_num = 6'(i);
          nv_pri = p;
        end
        nv_hit = 1'b1;
        if ({1'b0, p} > thr) nv_over = 1'b1;
      end
    end
  end

  always_comb begin
    fv_hit = 1'b0; fv_num = '0;
    for (int i = NS-1; i >= 0; i--)
      if (fpend[i]) begin
        fv_hit = 1'b1;
        fv_num = 6'(i);
      end
  end

  assign fast_irq = |fpend;
  assign norm_irq = (thr == 5'h1F) ? |npend : nv_over;

  wire rd_nv = bus_re && !bus_we && idx == IW'(16);
  wire rd_fv = bus_re && !bus_we && idx == IW'(17);

  always_comb begin
    pnext = (pend | (src_in & ~src_q)) & ~(~src_in & src_q);
    if (bus_we && idx == IW'(20)) pnext[63:32] = bus_wdata;
    if (bus_we && idx == IW'(21)) pnext[31:0]  = bus_wdata;
    if (rd_nv && nv_hit) pnext[nv_num] = 1'b0;
    if (rd_fv && fv_hit) pnext[fv_num] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0; en <= '0; typ <= '0; src_q <= '0;
      ctrl <= '0; thr <= 5'h1F;
      for (int k = 0; k < 8; k++) prio_w[k] <= '0;
    end else begin
      src_q <= src_in;
      pend  <= pnext;
      if (bus_we) begin
        case (idx)
          IW'(0):  ctrl <= bus_wdata & CTRL_MASK;
          IW'(1):  thr <= bus_wdata[4:0];
          IW'(2):  en[bus_wdata[5:0]] <= 1'b1;
          IW'(3):  en[bus_wdata[5:0]] <= 1'b0;
          IW'(4):  en[63:32] <= bus_wdata;
          IW'(5):  en[31:0]  <= bus_wdata;
          IW'(6):  typ[63:32] <= bus_wdata;
          IW'(7):  typ[31:0]  <= bus_wdata;
          IW'(8), IW'(9), IW'(10), IW'(11),
          IW'(12), IW'(13), IW'(14), IW'(15):
                   prio_w[3'(15 - int'(idx))] <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (idx)
      IW'(0):  bus_rdata = ctrl;
      IW'(1):  bus_rdata = {27'd0, thr};
      IW'(4):  bus_rdata = en[63:32];
      IW'(5):  bus_rdata = en[31:0];
      IW'(6):  bus_rdata = typ[63:32];
      IW'(7):  bus_rdata = typ[31:0];
      IW'(8), IW'(9), IW'(10), IW'(11),
      IW'(12), IW'(13), IW'(14), IW'(15):
               bus_rdata = prio_w[3'(15 - int'(idx))];
      IW'(16): bus_rdata = nv_hit ? {10'd0, nv_num, 12'd0, nv_pri} : 32'hFFFF_FFFF;
      IW'(17): bus_rdata = fv_hit ? {26'd0, fv_num} : 32'hFFFF_FFFF;
      IW'(18): bus_rdata = pend[63:32];
      IW'(19): bus_rdata = pend[31:0];
      IW'(22): bus_rdata = npend[63:32];
      IW'(23): bus_rdata = npend[31:0];
      IW'(24): bus_rdata = fpend[63:32];
      IW'(25): bus_rdata = fpend[31:0];
      default: bus_rdata = 32'd0;
    endcase
  end

  a_r2_enable_num: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && idx == IW'(2)) |=> en[$past(bus_wdata[5:0])]);
  a_r2_disable_num: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && idx == IW'(3)) |=> !en[$past(bus_wdata[5:0])]);
  a_r5_fast_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    fast_irq |-> (|(en & typ & pend)));
  a_r6_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (thr == 5'h1F && (|(pend & en & ~typ))) |-> norm_irq);
  a_r7_nvec_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_nv && nv_hit) |=> !pend[$past(nv_num)]);
  a_r8_fvec_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fv && fv_hit) |=> !pend[$past(fv_num)]);
  a_r10_force_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && idx == IW'(21)) |=> pend[31:0] == $past(bus_wdata));
endmodule

// File: tb/dual_irq_ctrl_tb.sv
module dual_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_in = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        norm_irq, fast_irq;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  dual_irq_ctrl u_dut (.clk, .rst_n, .src_in, .bus_addr, .bus_we, .bus_re,
                       .bus_wdata, .bus_rdata, .norm_irq, .fast_irq);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int w, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 12'(w * 4); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr_byte(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int w, output logic [31:0] v);
    @(negedge clk);
    bus_addr = 12'(w * 4); bus_re = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int w, input logic [31:0] exp);
    logic [31:0] v;
    rd(w, v);
    chk(req, v, exp);
  endtask

  task automatic clear_all();
    wr(4, 0); wr(5, 0); wr(6, 0); wr(7, 0); wr(20, 0); wr(21, 0); wr(1, 31);
  endtask

  task automatic t_reset();
    rd_chk("R1 thr", 1, 32'h1F);
    rd_chk("R1 en lo", 5, 0);
    rd_chk("R1 type hi", 6, 0);
    rd_chk("R1 prio", 15, 0);
    rd_chk("R1 ctrl", 0, 0);
    rd_chk("R1 pend lo", 19, 0);
    chk("R1 norm_irq", 32'(norm_irq), 0);
    chk("R1 fast_irq", 32'(fast_irq), 0);
  endtask

  task automatic t_en_num();
    wr(2, 32'h45);
    rd_chk("R2 en by num 5", 5, 32'h20);
    wr(2, 40);
    rd_chk("R2 en by num 40", 4, 32'h100);
    wr(3, 5);
    rd_chk("R2 dis by num 5", 5, 0);
    rd_chk("R2 enable-num reads 0", 2, 0);
    rd_chk("R2 disable-num reads 0", 3, 0);
    clear_all();
  endtask

  task automatic t_halves();
    wr(4, 32'hDEADBEEF); wr(7, 32'h0F0F1234);
    rd_chk("R3 en hi", 4, 32'hDEADBEEF);
    rd_chk("R3 en lo untouched", 5, 0);
    rd_chk("R3 type lo", 7, 32'h0F0F1234);
    rd_chk("R3 type hi untouched", 6, 0);
    clear_all();
  endtask

  task automatic t_prio();
    wr(15, 32'h76543210); wr(8, 32'hFEDCBA98); wr(14, 0);
    rd_chk("R4 prio word 15", 15, 32'h76543210);
    rd_chk("R4 prio word 8", 8, 32'hFEDCBA98);
    wr(5, 32'hFFFFFFFF); wr(4, 32'hFFFFFFFF);
    wr(20, 32'h8000_0000);
    rd_chk("R4 src 63 prio F", 16, 32'h003F_000F);
    clear_all();
  endtask

  task automatic t_normal();
    wr(5, 32'hFFFFFFFF);
    wr(21, 32'h28);
    chk("R6 bypass thr 1F", 32'(norm_irq), 1);
    wr(1, 4);
    chk("R6 prio5 > thr4", 32'(norm_irq), 1);
    wr(1, 5);
    chk("R6 prio5 not > thr5", 32'(norm_irq), 0);
    wr(1, 16);
    chk("R6 thr16 blocks all", 32'(norm_irq), 0);
    wr(1, 31);
    chk("R5 no fast with normal only", 32'(fast_irq), 0);
    rd_chk("R7 nvec highest prio", 16, 32'h0005_0005);
    rd_chk("R7 ack cleared src5", 19, 32'h8);
    wr(21, 32'h1100);
    rd_chk("R7 tie highest number", 16, 32'h000C_0000);
    rd_chk("R7 tie second", 16, 32'h0008_0000);
    rd_chk("R7 empty", 16, 32'hFFFFFFFF);
    chk("R6 no pending low", 32'(norm_irq), 0);
    clear_all();
  endtask

  task automatic t_fast();
    wr(5, 32'hFFFFFFFF); wr(7, 32'hF0);
    wr(21, 32'hA0);
    chk("R5 fast high", 32'(fast_irq), 1);
    chk("R6 fast-only gives no normal", 32'(norm_irq), 0);
    rd_chk("R10 masked fast lo", 25, 32'hA0);
    rd_chk("R10 masked normal lo", 23, 0);
    rd_chk("R8 fvec lowest", 17, 5);
    rd_chk("R8 fvec next", 17, 7);
    rd_chk("R8 fvec empty", 17, 32'hFFFFFFFF);
    chk("R5 fast low after acks", 32'(fast_irq), 0);
    wr(5, 0); wr(21, 32'h10);
    chk("R5 disabled no fast", 32'(fast_irq), 0);
    clear_all();
  endtask

  task automatic t_edges();
    logic [31:0] v;
    wr(4, 32'hFFFFFFFF); wr(5, 32'hFFFFFFFF);
    @(negedge clk); src_in[40] = 1'b1;
    @(negedge clk);
    chk("R9 rise sets norm_irq", 32'(norm_irq), 1);
    rd_chk("R9 rise sets pend", 18, 32'h100);
    rd_chk("R9 level hold keeps pend", 18, 32'h100);
    @(negedge clk); src_in[40] = 1'b0;
    @(negedge clk);
    chk("R9 fall clears norm_irq", 32'(norm_irq), 0);
    rd_chk("R9 fall clears pend", 18, 0);
    wr(7, 32'h8); wr(21, 32'h8);
    @(negedge clk);
    bus_addr = 12'(17 * 4); bus_re = 1'b1; src_in[3] = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); bus_re = 1'b0;
    chk("R9 ack read value", v, 3);
    rd_chk("R9 ack wins over rise", 19, 0);
    @(negedge clk); src_in = '0;
    @(negedge clk);
    clear_all();
  endtask

  task automatic t_force_ro();
    wr(20, 32'h12345678);
    rd_chk("R10 force hi raw", 18, 32'h12345678);
    rd_chk("R10 force reads 0", 20, 0);
    wr(19, 32'hFFFF);
    rd_chk("R11 raw lo ignores write", 19, 0);
    wr(16, 32'hFFFF);
    rd_chk("R11 vec write ignored", 18, 32'h12345678);
    wr(5, 32'h3); wr(1, 7);
    wr_byte(12'h100, 32'hFFFFFFFF);
    wr_byte(12'h2FC, 32'hFFFFFFFF);
    rd_chk("R11 vector range en kept", 5, 32'h3);
    rd_chk("R11 vector range thr kept", 1, 7);
    rd_chk("R11 unmapped read 0", 26, 0);
    rd_chk("R11 vector range read 0", 64, 0);
    wr(0, 32'hFFFFFFFF);
    rd_chk("R12 control mask", 0, 32'h017C0000);
    clear_all();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_en_num();
    t_halves();
    t_prio();
    t_normal();
    t_fast();
    t_edges();
    t_force_ro();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule